// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

The block runs one 16-bit up-counter and lets two independent channels stamp it. Each channel watches its own asynchronous input pin. The pin passes through a two-flop synchronizer, and a per-channel edge selection decides which transitions count. When a selected transition arrives, the channel copies the counter into its capture register and pulses its capture interrupt. The channel also reports the interval since its previous capture. If the counter wrapped in between, the interval includes a 0x10000 correction, so a single wrap still yields the true length. Because of this, software can measure two pulse widths or periods at the same time without doing any arithmetic.

The counter runs only while the `run_en` input is high. While `run_en` is low the counter is held at zero, so every run starts counting from zero. When the counter wraps it pulses an overflow interrupt and sets a sticky overflow flag that only software can clear. A small word-wide register port carries the edge configuration, the status (overflow and per-channel overrun) and read access to the counter and both capture registers. Reading a capture register acknowledges it. A new capture on a channel that was not acknowledged sets that channel's overrun bit.

Top module: `cap_timer_top`

## Requirements
- R1: While `run_en` is low at a clock edge, the counter becomes 0. While it is high, the counter increments by one per cycle and goes from 0xFFFF to 0x0000 without stopping.
- R2: An edge at which the counter goes from 0xFFFF to 0x0000 makes `ovf_irq` high for exactly the following cycle and sets status bit 0 at the same edge.
- R3: Status bit 0 stays set until a write to address 0 with `wdata[0]`=1. If a wrap falls on the same edge as that write, the bit stays set.
- R4: Config register (address 1) field `[2c+1:2c]` selects the edge for channel c: 0 rising, 1 falling, 2 both, 3 disabled. A pin level first sampled at edge k counts as an edge at edge k+2, but only if `run_en` is high there. At that edge `cap_irq[c]` goes high for one cycle.
- R5: A capture loads the counter value held just before the capturing edge into the channel's capture register (read at address 3+c). The register keeps that value until the next capture.
- R6: With each capture that has a predecessor, `ivl_vld[c]` pulses together with `cap_irq[c]`. `ivl_data[c]` (17 bits) then holds new minus previous if no wrap occurred since the previous capture on that channel, and otherwise 0x10000 + new − previous. A wrap on the capturing edge itself counts toward the next interval.
- R7: The first capture after `run_en` rises gives no valid interval. Dropping `run_en` discards each channel's history.
- R8: Status bit 1+c (overrun) sets when channel c captures while its previous capture is unread. A read is `rd_en` with address 3+c at an earlier edge or at the same edge as the capture. Writing 1 to bit 1+c at address 0 clears the overrun bit, except that a new overrun at that edge wins.
- R9: Address 2 reads the counter. Addresses 5 to 7 read 0. After reset the status, config, counter and capture registers are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Count enable; counter held at zero while low |
| cap_pin | input | 2 | Asynchronous capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acknowledges capture reads) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| cap_irq | output | 2 | One-cycle capture pulse per channel |
| ivl_vld | output | 2 | One-cycle interval-valid pulse per channel |
| ivl_data | output | 2x17 | Per-channel interval, packed [channel][16:0] |
| ovf_irq | output | 1 | One-cycle counter overflow pulse |

## Verification
A missed or extra synchronizer stage shows up as `cap_irq` one cycle early or late on the first transition. A wrong edge decode shows up as a pulse on a transition that is not selected, or a missing pulse on one that is. A wrap record that is never cleared, or never set, corrupts the next `ivl_data` by exactly 0x10000 at the very next capture, so it surfaces within one capture period. Stale unread or overrun state appears in the status word at the first read after the offending capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_OFF  = 2'd3
    } edge_sel_e;
endpackage

// File: rtl/cap_counter.sv
module cap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (run) d.cnt = q.cnt + 1'b1;
        else     d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt  = q.cnt;
    assign wrap = run && (q.cnt == MAXV);

    // R1: steps by one while running, returns to zero while stopped
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt == $past(cnt) + 1'b1);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/cap_sync.sv
module cap_sync
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    input  logic       run,
    output logic       hit
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } st_t;

    st_t  d, q;
    logic rise, fall;

    always_comb begin
        d.s1 = pin;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise = q.s2 & ~q.s3;
    assign fall = ~q.s2 & q.s3;

    always_comb begin
        unique case (sel)
            EDGE_RISE: hit = run & rise;
            EDGE_FALL: hit = run & fall;
            EDGE_BOTH: hit = run & (rise | fall);
            default:   hit = 1'b0;
        endcase
    end

    // R4: a disabled channel never reports an edge
    a_r4_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_OFF) |-> !hit);
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         hit,
    input  logic [W-1:0] cnt,
    input  logic         wrap,
    input  logic         rd_cap,
    input  logic         clr_ovr,
    output logic [W-1:0] cap,
    output logic         irq,
    output logic [W:0]   ivl,
    output logic         ivl_vld,
    output logic         ovr
);
    localparam logic [W:0] WRAP_ADD = {1'b1, {W{1'b0}}};

    typedef struct packed {
        logic [W-1:0] cap;
        logic [W:0]   ivl;
        logic         irq;
        logic         vld;
        logic         have;
        logic         wseen;
        logic         unread;
        logic         ovr;
    } st_t;

    st_t  d, q;
    logic ovr_set;

    always_comb begin
        d       = q;
        d.irq   = 1'b0;
        d.vld   = 1'b0;
        ovr_set = hit & q.unread & ~rd_cap;
        if (hit) begin
            d.cap    = cnt;
            d.irq    = 1'b1;
            d.vld    = q.have;
            d.ivl    = {1'b0, cnt} - {1'b0, q.cap} + (q.wseen ? WRAP_ADD : '0);
            d.have   = 1'b1;
            d.wseen  = wrap;
            d.unread = 1'b1;
        end else begin
            d.wseen = q.wseen | wrap;
            if (rd_cap) d.unread = 1'b0;
        end
        d.ovr = ovr_set | (q.ovr & ~clr_ovr);
        if (!run) begin
            d.have  = 1'b0;
            d.wseen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cap     = q.cap;
    assign irq     = q.irq;
    assign ivl     = q.ivl;
    assign ivl_vld = q.vld;
    assign ovr     = q.ovr;

    // R6: a valid interval only comes with a capture
    a_r6_vld_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_vld |-> irq);
    // R6: low bits of the interval equal the difference of the two captures
    a_r6_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_vld |-> ivl[W-1:0] == cap - $past(cap));
    // R8: overrun stays set without a clear
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !clr_ovr |=> ovr);
endmodule

// File: rtl/cap_timer_top.sv
module cap_timer_top #(
    parameter int W   = 16,
    parameter int NCH = 2,
    parameter int AW  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    input  logic [NCH-1:0]        cap_pin,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [AW-1:0]         addr,
    input  logic [W-1:0]          wdata,
    output logic [W-1:0]          rdata,
    output logic [NCH-1:0]        cap_irq,
    output logic [NCH-1:0]        ivl_vld,
    output logic [NCH-1:0][W:0]   ivl_data,
    output logic                  ovf_irq
);
    localparam int CFG_W = 2 * NCH;
    localparam logic [AW-1:0] A_STAT = AW'(0);
    localparam logic [AW-1:0] A_CFG  = AW'(1);
    localparam logic [AW-1:0] A_CNT  = AW'(2);
    localparam int CAP_BASE = 3;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             ovf;
        logic             ovf_irq;
    } st_t;

    st_t                    d, q;
    logic [W-1:0]           cnt;
    logic                   wrap;
    logic                   wr_stat;
    logic [NCH-1:0]         hit;
    logic [NCH-1:0]         ovr;
    logic [NCH-1:0][W-1:0]  cap;
    logic                   unused_wdata;

    assign unused_wdata = ^wdata;
    assign wr_stat = wr_en && (addr == A_STAT);

    cap_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_en), .cnt(cnt), .wrap(wrap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic rd_cap;
        assign rd_cap = rd_en && (addr == AW'(CAP_BASE + c));

        cap_sync u_sync (
            .clk(clk), .rst_n(rst_n), .pin(cap_pin[c]),
            .sel(q.cfg[2*c +: 2]), .run(run_en), .hit(hit[c])
        );

        cap_channel #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n), .run(run_en), .hit(hit[c]),
            .cnt(cnt), .wrap(wrap), .rd_cap(rd_cap),
            .clr_ovr(wr_stat && wdata[1 + c]),
            .cap(cap[c]), .irq(cap_irq[c]), .ivl(ivl_data[c]),
            .ivl_vld(ivl_vld[c]), .ovr(ovr[c])
        );
    end

    always_comb begin
        d         = q;
        d.ovf_irq = wrap;
        d.ovf     = wrap | (q.ovf & ~(wr_stat && wdata[0]));
        if (wr_en && (addr == A_CFG)) d.cfg = wdata[CFG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_STAT)      rdata = W'({ovr, q.ovf});
        else if (addr == A_CFG)  rdata = W'(q.cfg);
        else if (addr == A_CNT)  rdata = cnt;
        else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == AW'(CAP_BASE + c)) rdata = cap[c];
            end
        end
    end

    assign ovf_irq = q.ovf_irq;

    // R2: the overflow pulse always coincides with a set flag
    a_r2_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> q.ovf);
    // R2: the pulse lasts one cycle at a time (wraps are far apart)
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |=> !ovf_irq);
    // R3: the flag holds until software clears it
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf && !(wr_stat && wdata[0]) |=> q.ovf);
endmodule

// File: tb/tb_cap_timer_top.sv
module tb_cap_timer_top;
    localparam int W = 16;
    localparam int NCH = 2;
    localparam int NCYC = 150000;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  run_en = 1'b0;
    logic [NCH-1:0]        cap_pin = '0;
    logic                  wr_en = 1'b0;
    logic                  rd_en = 1'b0;
    logic [2:0]            addr = '0;
    logic [W-1:0]          wdata = '0;
    logic [W-1:0]          rdata;
    logic [NCH-1:0]        cap_irq;
    logic [NCH-1:0]        ivl_vld;
    logic [NCH-1:0][W:0]   ivl_data;
    logic                  ovf_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cap_timer_top dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cap_pin(cap_pin),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_irq(cap_irq), .ivl_vld(ivl_vld),
        .ivl_data(ivl_data), .ovf_irq(ovf_irq)
    );

    // reference model state, advanced at every rising edge
    logic [W-1:0]         m_cnt;
    logic                 m_ovf, m_ovf_irq;
    logic [3:0]           m_cfg;
    logic [NCH-1:0]       m_s1, m_s2, m_s3;
    logic [NCH-1:0][W-1:0] m_cap;
    logic [NCH-1:0]       m_have, m_wseen, m_unread, m_ovr;
    logic [NCH-1:0]       e_irq, e_vld;
    logic [NCH-1:0][W:0]  e_ivl;
    logic                 t_wrap, t_hit, t_rd, t_set, t_rise, t_fall;
    logic [1:0]           t_sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_ovf = 0; m_ovf_irq = 0; m_cfg = '0;
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_cap = '0;
            m_have = '0; m_wseen = '0; m_unread = '0; m_ovr = '0;
            e_irq = '0; e_vld = '0; e_ivl = '0;
        end else begin
            t_wrap = run_en && (m_cnt == 16'hFFFF);
            for (int c = 0; c < NCH; c++) begin
                t_rise = m_s2[c] & ~m_s3[c];
                t_fall = ~m_s2[c] & m_s3[c];
                t_sel  = m_cfg[2*c +: 2];
                t_hit  = run_en && ((t_sel == 2'd0 && t_rise) || (t_sel == 2'd1 && t_fall) ||
                                    (t_sel == 2'd2 && (t_rise || t_fall)));
                t_rd   = rd_en && (addr == 3'(3 + c));
                t_set  = t_hit && m_unread[c] && !t_rd;
                e_irq[c] = t_hit;
                e_vld[c] = t_hit && m_have[c];
                if (t_hit) begin
                    e_ivl[c] = ({1'b0, m_cnt} - {1'b0, m_cap[c]}) +
                               (m_wseen[c] ? 17'h10000 : 17'h0);
                    m_cap[c] = m_cnt;
                    m_have[c] = 1'b1;
                    m_wseen[c] = t_wrap;
                    m_unread[c] = 1'b1;
                end else begin
                    m_wseen[c] = m_wseen[c] | t_wrap;
                    if (t_rd) m_unread[c] = 1'b0;
                end
                m_ovr[c] = t_set | (m_ovr[c] & ~(wr_en && addr == 3'd0 && wdata[1 + c]));
                if (!run_en) begin
                    m_have[c] = 1'b0;
                    m_wseen[c] = 1'b0;
                end
            end
            m_ovf_irq = t_wrap;
            m_ovf = t_wrap | (m_ovf & ~(wr_en && addr == 3'd0 && wdata[0]));
            if (wr_en && addr == 3'd1) m_cfg = wdata[3:0];
            m_cnt = run_en ? m_cnt + 1'b1 : '0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return W'({m_ovr, m_ovf});
            3'd1: return W'(m_cfg);
            3'd2: return m_cnt;
            3'd3: return m_cap[0];
            3'd4: return m_cap[1];
            default: return '0;
        endcase
    endfunction

    task automatic check_read(input logic [2:0] a);
        addr = a;
        #1;
        case (a)
            3'd0: check(rdata == exp_read(a), "R3 R8 status read", 32'(rdata), 32'(exp_read(a)));
            3'd1: check(rdata == exp_read(a), "R4 config read", 32'(rdata), 32'(exp_read(a)));
            3'd2: check(rdata == exp_read(a), "R1 counter read", 32'(rdata), 32'(exp_read(a)));
            3'd3, 3'd4: check(rdata == exp_read(a), "R5 capture read", 32'(rdata), 32'(exp_read(a)));
            default: check(rdata == exp_read(a), "R9 unmapped read", 32'(rdata), 32'(exp_read(a)));
        endcase
    endtask

    task automatic check_outputs();
        check(cap_irq == e_irq, "R4 capture irq", 32'(cap_irq), 32'(e_irq));
        check(ivl_vld == e_vld, "R7 interval valid", 32'(ivl_vld), 32'(e_vld));
        check(ovf_irq == m_ovf_irq, "R2 overflow irq", 32'(ovf_irq), 32'(m_ovf_irq));
        for (int c = 0; c < NCH; c++) begin
            if (e_vld[c])
                check(ivl_data[c] == e_ivl[c], "R6 interval value",
                      32'(ivl_data[c]), 32'(e_ivl[c]));
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int den;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state of every address
        for (int a = 0; a < 8; a++) check_read(3'(a));
        check(rdata == 16'h0, "R9 reset unmapped", 32'(rdata), 32'h0);

        // directed: both edges on channel 0, falling on channel 1
        wr_en = 1'b1; addr = 3'd1; wdata = 16'h0006;
        @(negedge clk);
        wr_en = 1'b0;
        run_en = 1'b1;

        for (int i = 0; i < NCYC; i++) begin
            @(negedge clk);
            check_outputs();
            wr_en = 1'b0; rd_en = 1'b0;
            // R7: drop the enable briefly to discard history
            if (i >= 3000 && i < 3010) run_en = 1'b0;
            else if (i == 3010) run_en = 1'b1;
            // R4: channel 1 disabled for a while, toggles must be silent
            if (i == 5000) begin
                wr_en = 1'b1; addr = 3'd1; wdata = 16'h000E;
            end else if (i == 6000) begin
                wr_en = 1'b1; addr = 3'd1; wdata = 16'h0002;
            end else if (i < 20000 && ($urandom % 300) == 0 && i != 5999) begin
                wr_en = 1'b1; addr = 3'd1; wdata = 16'($urandom % 16);
            end else if (i % 50000 == 49999) begin
                wr_en = 1'b1; addr = 3'd0; wdata = 16'h0007;
            end else if (($urandom % 2000) == 0) begin
                wr_en = 1'b1; addr = 3'd0; wdata = 16'($urandom % 8);
            end
            den = (i < 20000) ? 7 : ((i < 80000) ? 9000 : 30000);
            for (int c = 0; c < NCH; c++) begin
                if (($urandom % den) == 0) cap_pin[c] = ~cap_pin[c];
            end
            if (!wr_en && ($urandom % ((i < 20000) ? 4 : 60)) == 0) begin
                rd_en = 1'b1;
                check_read(3'($urandom % 8));
            end
        end

        @(negedge clk);
        check_outputs();
        wr_en = 1'b0; rd_en = 1'b0;
        for (int a = 0; a < 5; a++) check_read(3'(a));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule